// File: doc/BRIEF.md
# Cache Line Fetch Request Unit

This block sits at the front of an instruction fetch pipeline shared by several hardware threads. Each thread owns one line buffer. When the fetch logic presents a program counter and a thread number, the unit aligns the address down to the start of its cache line. If that thread's buffer already holds the line, the unit reports a hit at once. If not, it sends a line read request to the memory side, tagged with the thread number and a short request id.

The memory side may refuse a request. The refused request is then parked in a single retry slot shared by all threads, and all new requests stop until the memory side signals a retry. Responses carry the thread number and request id back. A response is written into the line buffer only if that thread is still waiting and the id matches the one it is waiting for. Anything else is dropped. A squash cancels a thread's outstanding work. Address translation happens outside the block and is seen here only as a fault input that prevents a request.

Top module: `line_fetch_unit`

## Requirements
- R1: While `fetch_valid` is high and the selected thread's buffer is valid with a tag equal to `fetch_pc` with its low log2(LINE_BYTES) bits cleared, `fetch_hit` is high, no new request is issued, and `line_data` shows that buffer's line.
- R2: On a miss the unit drives `mem_req_valid` in the same cycle, with `mem_req_addr` set to the aligned address, `mem_req_tid` set to the fetching thread, and `mem_req_rid` set to a counter. The counter is 0 after reset, advances by one for each newly issued request (modulo 2^RID_W), and is not advanced by resends. An accepted request puts the thread in state 1 (waiting for a response).
- R3: No new request is issued in any of these cases: `cache_blocked` is high; `irq_pending` is high and `fetch_pc[1:0]` is 00; `xlate_fault` is high; or the thread is in state 1 or 2.
- R4: A request presented while `mem_req_ready` is low is refused. The thread goes to state 2 (waiting for a retry), the request is parked, and `cache_blocked` rises on the next cycle.
- R5: A `mem_retry` pulse while a request is parked re-presents it with the same address, thread and id. If it is accepted, the thread goes to state 1 and `cache_blocked` falls. If it is refused, everything stays as it was. A `mem_retry` pulse with the slot empty only clears `cache_blocked`.
- R6: Squashing the thread that owns the parked request empties the slot but leaves `cache_blocked` high. The next `mem_retry` then re-presents nothing.
- R7: An accepted response stores `mem_rsp_data` and marks the buffer valid. The thread goes to state 3 (blocked) if its `stall_in` bit is high, and to state 4 (access complete) if it is low.
- R8: A response is dropped, with `rsp_drop` high for that cycle and no change to the buffer or the thread state, when the thread is not in state 1 or when `mem_rsp_rid` differs from that thread's outstanding id.
- R9: `squash_valid` moves the thread to state 5 and clears its outstanding id. A response for the same thread in the same cycle is dropped.
- R10: After reset every thread is in state 0 (running), every buffer is invalid, `cache_blocked` is low, and no request is presented while inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch lookup present |
| fetch_tid | input | TID_W | Thread of the lookup |
| fetch_pc | input | ADDR_W | Program counter to look up |
| xlate_fault | input | 1 | Translation fault for this lookup; no request |
| irq_pending | input | 1 | Interrupt pending; holds requests for PCs with low bits 00 |
| stall_in | input | THREADS | Per-thread downstream stall |
| squash_valid | input | 1 | Squash a thread |
| squash_tid | input | TID_W | Thread to squash |
| fetch_hit | output | 1 | Buffered line covers the lookup PC |
| line_data | output | LINE_BYTES*8 | Line buffer of the looked-up thread |
| mem_req_valid | output | 1 | Line request presented |
| mem_req_ready | input | 1 | Memory side accepts the request this cycle |
| mem_req_addr | output | ADDR_W | Line-aligned request address |
| mem_req_tid | output | TID_W | Request thread |
| mem_req_rid | output | RID_W | Request id |
| mem_retry | input | 1 | Memory side can take a refused request again |
| mem_rsp_valid | input | 1 | Line response present |
| mem_rsp_tid | input | TID_W | Response thread |
| mem_rsp_rid | input | RID_W | Response id |
| mem_rsp_data | input | LINE_BYTES*8 | Response line |
| rsp_drop | output | 1 | Response discarded as stale |
| cache_blocked | output | 1 | New requests held off by a refusal |
| thr_state | output | THREADS*3 | Per-thread state codes 0..5, thread t at bits 3t+2:3t |

## Verification
The bench provokes two overlaps. In the first, a response arrives in the same cycle as a squash of its own thread; the response must be reported dropped and the thread must end in state 5. A later lookup of the same line must miss and issue a fresh id, which shows that the line was never written. In the second, a squash of the retry-slot owner is followed by a retry pulse; that pulse must present nothing and only release the block. A stale response carrying the squashed id must then also be dropped.

// File: rtl/lfu_pkg.sv
package lfu_pkg;

  typedef enum logic [2:0] {
    TS_RUN        = 3'd0,
    TS_WAIT_RSP   = 3'd1,
    TS_WAIT_RETRY = 3'd2,
    TS_BLOCKED    = 3'd3,
    TS_DONE       = 3'd4,
    TS_SQUASH     = 3'd5
  } thr_st_e;

endpackage

// File: rtl/lfu_line_buf.sv
module lfu_line_buf #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_en,
  input  logic [ADDR_W-1:0]    issue_tag,
  input  logic                 fill_en,
  input  logic [LINE_BITS-1:0] fill_data,
  output logic                 valid_o,
  output logic [ADDR_W-1:0]    tag_o,
  output logic [LINE_BITS-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      data_o  <= '0;
    end else if (issue_en) begin
      tag_o   <= issue_tag;
      valid_o <= 1'b0;
    end else if (fill_en) begin
      data_o  <= fill_data;
      valid_o <= 1'b1;
    end
  end

endmodule

// File: rtl/lfu_retry_slot.sv
module lfu_retry_slot #(
  parameter int ADDR_W = 32,
  parameter int TID_W  = 1,
  parameter int RID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              park,
  input  logic [ADDR_W-1:0] park_addr,
  input  logic [TID_W-1:0]  park_tid,
  input  logic [RID_W-1:0]  park_rid,
  input  logic              drop,
  input  logic              clr_block,
  output logic              full_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [TID_W-1:0]  tid_o,
  output logic [RID_W-1:0]  rid_o,
  output logic              blocked_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_o    <= 1'b0;
      blocked_o <= 1'b0;
      addr_o    <= '0;
      tid_o     <= '0;
      rid_o     <= '0;
    end else if (park) begin
      full_o    <= 1'b1;
      blocked_o <= 1'b1;
      addr_o    <= park_addr;
      tid_o     <= park_tid;
      rid_o     <= park_rid;
    end else begin
      if (drop)      full_o    <= 1'b0;
      if (clr_block) blocked_o <= 1'b0;
    end
  end

  // R4: a parked request always keeps new requests blocked
  p_slot_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> blocked_o);

  // R6: dropping without a retry leaves the block in place
  p_drop_keeps_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && drop && !clr_block && !park) |=> (!full_o && blocked_o));

endmodule

// File: rtl/lfu_thread_ctl.sv
module lfu_thread_ctl import lfu_pkg::*; #(
  parameter int RID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             squash,
  input  logic             rsp_accept,
  input  logic             stall,
  input  logic             retry_ok,
  input  logic             issue_ok,
  input  logic             issue_refused,
  input  logic [RID_W-1:0] issue_rid,
  output thr_st_e          state_o,
  output logic [RID_W-1:0] out_rid_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_o   <= TS_RUN;
      out_rid_o <= '0;
    end else if (squash) begin
      state_o   <= TS_SQUASH;
      out_rid_o <= '0;
    end else if (rsp_accept) begin
      state_o   <= stall ? TS_BLOCKED : TS_DONE;
    end else if (retry_ok) begin
      state_o   <= TS_WAIT_RSP;
    end else if (issue_ok) begin
      state_o   <= TS_WAIT_RSP;
      out_rid_o <= issue_rid;
    end else if (issue_refused) begin
      state_o   <= TS_WAIT_RETRY;
      out_rid_o <= issue_rid;
    end
  end

  // R7: a response is only ever accepted while waiting for one
  p_accept_while_waiting_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_accept |-> (state_o == TS_WAIT_RSP));

endmodule

// File: rtl/line_fetch_unit.sv
module line_fetch_unit import lfu_pkg::*; #(
  parameter int THREADS    = 2,
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int RID_W      = 4,
  localparam int TID_W     = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int OFF_W     = $clog2(LINE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_valid,
  input  logic [TID_W-1:0]      fetch_tid,
  input  logic [ADDR_W-1:0]     fetch_pc,
  input  logic                  xlate_fault,
  input  logic                  irq_pending,
  input  logic [THREADS-1:0]    stall_in,
  input  logic                  squash_valid,
  input  logic [TID_W-1:0]      squash_tid,
  output logic                  fetch_hit,
  output logic [LINE_BITS-1:0]  line_data,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [TID_W-1:0]      mem_req_tid,
  output logic [RID_W-1:0]      mem_req_rid,
  input  logic                  mem_retry,
  input  logic                  mem_rsp_valid,
  input  logic [TID_W-1:0]      mem_rsp_tid,
  input  logic [RID_W-1:0]      mem_rsp_rid,
  input  logic [LINE_BITS-1:0]  mem_rsp_data,
  output logic                  rsp_drop,
  output logic                  cache_blocked,
  output logic [THREADS*3-1:0]  thr_state
);

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] pc);
    return pc & ~ADDR_W'(LINE_BYTES - 1);
  endfunction

  function automatic logic irq_holds(input logic irq, input logic [ADDR_W-1:0] pc);
    return irq && (pc[1:0] == 2'b00);
  endfunction

  // per-thread state
  logic                 buf_valid [THREADS];
  logic [ADDR_W-1:0]    buf_tag   [THREADS];
  logic [LINE_BITS-1:0] buf_data  [THREADS];
  thr_st_e              st        [THREADS];
  logic [RID_W-1:0]     orid      [THREADS];

  // retry slot
  logic              slot_full;
  logic [ADDR_W-1:0] slot_addr;
  logic [TID_W-1:0]  slot_tid;
  logic [RID_W-1:0]  slot_rid;

  logic [RID_W-1:0]  rid_ctr;

  // named events
  logic              fetch_tid_ok, rsp_tid_ok;
  logic [ADDR_W-1:0] fetch_base;
  logic              thr_busy;
  logic              resend_go, resend_ok;
  logic              new_go, new_ok, new_ref;
  logic              owner_squash, rsp_hit;
  logic              slot_drop, slot_clr;

  assign fetch_tid_ok = int'(fetch_tid) < THREADS;
  assign rsp_tid_ok   = int'(mem_rsp_tid) < THREADS;
  assign fetch_base   = line_base(fetch_pc);

  always_comb begin
    fetch_hit = 1'b0;
    thr_busy  = 1'b0;
    line_data = '0;
    if (fetch_tid_ok) begin
      fetch_hit = fetch_valid && buf_valid[fetch_tid] && (buf_tag[fetch_tid] == fetch_base);
      thr_busy  = (st[fetch_tid] == TS_WAIT_RSP) || (st[fetch_tid] == TS_WAIT_RETRY);
      line_data = buf_data[fetch_tid];
    end
  end

  assign owner_squash = slot_full && squash_valid && (squash_tid == slot_tid);
  assign resend_go    = mem_retry && slot_full && !owner_squash;
  assign resend_ok    = resend_go && mem_req_ready;

  assign new_go = fetch_valid && fetch_tid_ok && !fetch_hit && !cache_blocked &&
                  !irq_holds(irq_pending, fetch_pc) && !xlate_fault && !thr_busy &&
                  !resend_go && !(squash_valid && (squash_tid == fetch_tid));
  assign new_ok  = new_go && mem_req_ready;
  assign new_ref = new_go && !mem_req_ready;

  assign mem_req_valid = resend_go || new_go;
  assign mem_req_addr  = resend_go ? slot_addr : fetch_base;
  assign mem_req_tid   = resend_go ? slot_tid  : fetch_tid;
  assign mem_req_rid   = resend_go ? slot_rid  : rid_ctr;

  always_comb begin
    rsp_hit = 1'b0;
    if (mem_rsp_valid && rsp_tid_ok)
      rsp_hit = (st[mem_rsp_tid] == TS_WAIT_RSP) && (mem_rsp_rid == orid[mem_rsp_tid]) &&
                !(squash_valid && (squash_tid == mem_rsp_tid));
  end
  assign rsp_drop = mem_rsp_valid && !rsp_hit;

  assign slot_drop = resend_ok || owner_squash;
  assign slot_clr  = mem_retry && (!slot_full || resend_ok || owner_squash);

  always_ff @(posedge clk) begin
    if (!rst_n)      rid_ctr <= '0;
    else if (new_go) rid_ctr <= rid_ctr + 1'b1;
  end

  lfu_retry_slot #(.ADDR_W(ADDR_W), .TID_W(TID_W), .RID_W(RID_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .park      (new_ref),
    .park_addr (fetch_base),
    .park_tid  (fetch_tid),
    .park_rid  (rid_ctr),
    .drop      (slot_drop),
    .clr_block (slot_clr),
    .full_o    (slot_full),
    .addr_o    (slot_addr),
    .tid_o     (slot_tid),
    .rid_o     (slot_rid),
    .blocked_o (cache_blocked)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    localparam logic [TID_W-1:0] TID = TID_W'(t);
    logic sel_fetch, sel_rsp, sel_slot, sel_sq;
    assign sel_fetch = (fetch_tid == TID);
    assign sel_rsp   = (mem_rsp_tid == TID);
    assign sel_slot  = (slot_tid == TID);
    assign sel_sq    = squash_valid && (squash_tid == TID);

    lfu_line_buf #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_en  (new_go && sel_fetch),
      .issue_tag (fetch_base),
      .fill_en   (rsp_hit && sel_rsp),
      .fill_data (mem_rsp_data),
      .valid_o   (buf_valid[t]),
      .tag_o     (buf_tag[t]),
      .data_o    (buf_data[t])
    );

    lfu_thread_ctl #(.RID_W(RID_W)) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .squash        (sel_sq),
      .rsp_accept    (rsp_hit && sel_rsp),
      .stall         (stall_in[t]),
      .retry_ok      (resend_ok && sel_slot),
      .issue_ok      (new_ok && sel_fetch),
      .issue_refused (new_ref && sel_fetch),
      .issue_rid     (rid_ctr),
      .state_o       (st[t]),
      .out_rid_o     (orid[t])
    );

    assign thr_state[t*3 +: 3] = st[t];
  end

  // R2: requests are always line aligned
  p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

  // R2: id counter steps by one per new request
  p_rid_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_go |=> (rid_ctr == $past(rid_ctr) + 1'b1));

  // R1: a hit never produces a request unless a retry resends
  p_hit_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hit && !mem_retry) |-> !mem_req_valid);

  // R3: blocked means no request outside a retry pulse
  p_blocked_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_blocked && !mem_retry) |-> !mem_req_valid);

  // R4: refusal raises the block on the next cycle
  p_refuse_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> cache_blocked);

  // R9: a response meeting a squash of its thread is dropped
  p_squash_drops_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && squash_valid && (squash_tid == mem_rsp_tid)) |-> rsp_drop);

endmodule

// File: tb/line_fetch_unit_tb.sv
module line_fetch_unit_tb;

  localparam int THREADS = 2;
  localparam int LB      = 512;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fetch_valid;
  logic [0:0]    fetch_tid;
  logic [31:0]   fetch_pc;
  logic          xlate_fault, irq_pending;
  logic [1:0]    stall_in;
  logic          squash_valid;
  logic [0:0]    squash_tid;
  logic          fetch_hit;
  logic [LB-1:0] line_data;
  logic          mem_req_valid, mem_req_ready;
  logic [31:0]   mem_req_addr;
  logic [0:0]    mem_req_tid;
  logic [3:0]    mem_req_rid;
  logic          mem_retry, mem_rsp_valid;
  logic [0:0]    mem_rsp_tid;
  logic [3:0]    mem_rsp_rid;
  logic [LB-1:0] mem_rsp_data;
  logic          rsp_drop, cache_blocked;
  logic [5:0]    thr_state;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_rid = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  line_fetch_unit #(.THREADS(THREADS)) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_tid(fetch_tid),
    .fetch_pc(fetch_pc), .xlate_fault(xlate_fault), .irq_pending(irq_pending),
    .stall_in(stall_in), .squash_valid(squash_valid), .squash_tid(squash_tid),
    .fetch_hit(fetch_hit), .line_data(line_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_tid(mem_req_tid),
    .mem_req_rid(mem_req_rid), .mem_retry(mem_retry), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_tid(mem_rsp_tid), .mem_rsp_rid(mem_rsp_rid), .mem_rsp_data(mem_rsp_data),
    .rsp_drop(rsp_drop), .cache_blocked(cache_blocked), .thr_state(thr_state)
  );

  function automatic logic [LB-1:0] mk_line(input logic [31:0] seed);
    return {16{seed}};
  endfunction

  function automatic logic [2:0] st_of(input int t);
    return thr_state[t*3 +: 3];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 0; fetch_tid = 0; fetch_pc = 0; xlate_fault = 0; irq_pending = 0;
    squash_valid = 0; squash_tid = 0; mem_req_ready = 1; mem_retry = 0;
    mem_rsp_valid = 0; mem_rsp_tid = 0; mem_rsp_rid = 0; mem_rsp_data = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic set_fetch(input int tid, input logic [31:0] pc, input logic rdy);
    fetch_valid = 1; fetch_tid = tid[0:0]; fetch_pc = pc; mem_req_ready = rdy;
  endtask

  task automatic set_rsp(input int tid, input int rid, input logic [LB-1:0] d);
    mem_rsp_valid = 1; mem_rsp_tid = tid[0:0]; mem_rsp_rid = rid[3:0]; mem_rsp_data = d;
  endtask

  task automatic chk_req(input string req, input int tid, input logic [31:0] addr, input int rid);
    chk(req, {63'd0, mem_req_valid}, 64'd1);
    chk(req, {32'd0, mem_req_addr}, {32'd0, addr});
    chk(req, {63'd0, mem_req_tid}, tid);
    chk(req, {60'd0, mem_req_rid}, rid[3:0]);
  endtask

  // issue and fill one line, accepted at once
  task automatic fill(input int tid, input logic [31:0] pc, input logic [LB-1:0] d);
    int rid;
    rid = exp_rid;
    set_fetch(tid, pc, 1'b1); #1;
    chk_req("R2 miss request", tid, pc & ~32'h3F, rid);
    tick(); exp_rid++;
    chk("R2 waiting state", st_of(tid), 1);
    set_rsp(tid, rid, d); #1;
    chk("R7 accepted no drop", rsp_drop, 0);
    tick();
    chk("R7 done state", st_of(tid), 4);
  endtask

  task automatic t_reset();
    idle(); #1;
    chk("R10 state t0", st_of(0), 0);
    chk("R10 state t1", st_of(1), 0);
    chk("R10 not blocked", cache_blocked, 0);
    chk("R10 no request", mem_req_valid, 0);
    fetch_valid = 1; fetch_pc = 32'h0; #1;
    chk("R10 buffers invalid", fetch_hit, 0);
    idle();
  endtask

  task automatic t_hit();
    fill(0, 32'h0000_1234, mk_line(32'hA1));
    set_fetch(0, 32'h0000_123C, 1'b1); #1;
    chk("R1 hit", fetch_hit, 1);
    chk("R1 no request", mem_req_valid, 0);
    chk("R1 line low", line_data[63:0], mk_line(32'hA1) >> 0);
    chk("R1 line high", line_data[511:448], {2{32'hA1}});
    set_fetch(1, 32'h0000_1234, 1'b1); #1;
    chk("R1 other thread misses", fetch_hit, 0);
    idle();
  endtask

  task automatic t_stall_fill();
    int rid;
    rid = exp_rid;
    set_fetch(1, 32'h8000_0044, 1'b1); #1;
    chk_req("R2 second thread", 1, 32'h8000_0040, rid);
    tick(); exp_rid++;
    stall_in = 2'b10;
    set_rsp(1, rid, mk_line(32'hB2));
    tick();
    stall_in = 2'b00;
    chk("R7 stalled fill blocked", st_of(1), 3);
    set_fetch(1, 32'h8000_0078, 1'b1); #1;
    chk("R7 stalled fill hit", fetch_hit, 1);
    idle();
  endtask

  task automatic t_stale();
    int rid;
    rid = exp_rid;
    set_fetch(0, 32'h0000_2000, 1'b1); tick(); exp_rid++;
    set_rsp(0, rid + 3, mk_line(32'hEE)); #1;
    chk("R8 id mismatch drop", rsp_drop, 1);
    tick();
    chk("R8 state kept", st_of(0), 1);
    set_rsp(0, rid, mk_line(32'hC3)); tick();
    chk("R7 fill after stale", st_of(0), 4);
    set_rsp(0, rid, mk_line(32'hDD)); #1;
    chk("R8 not waiting drop", rsp_drop, 1);
    tick();
    set_fetch(0, 32'h0000_2010, 1'b1); #1;
    chk("R8 line unchanged", line_data[31:0], 32'hC3);
    chk("R8 state unchanged", st_of(0), 4);
    idle();
  endtask

  task automatic t_gate();
    int rid;
    irq_pending = 1; set_fetch(0, 32'h0000_3000, 1'b1); #1;
    chk("R3 irq holds aligned pc", mem_req_valid, 0);
    tick();
    chk("R3 irq no state change", st_of(0), 4);
    rid = exp_rid;
    irq_pending = 1; set_fetch(0, 32'h0000_3002, 1'b1); #1;
    chk_req("R3 irq passes low bits", 0, 32'h0000_3000, rid);
    tick(); exp_rid++;
    set_fetch(0, 32'h0000_4000, 1'b1); #1;
    chk("R3 waiting thread no request", mem_req_valid, 0);
    set_fetch(1, 32'h0000_5000, 1'b1); xlate_fault = 1; #1;
    chk("R3 fault no request", mem_req_valid, 0);
    idle();
    set_rsp(0, rid, mk_line(32'h33)); tick();
    chk("R3 resolve", st_of(0), 4);
  endtask

  task automatic t_refuse_retry();
    int rid;
    rid = exp_rid;
    set_fetch(1, 32'h0000_6008, 1'b0); #1;
    chk_req("R4 refused request shown", 1, 32'h0000_6000, rid);
    tick(); exp_rid++;
    chk("R4 wait retry state", st_of(1), 2);
    chk("R4 blocked", cache_blocked, 1);
    set_fetch(0, 32'h0000_7000, 1'b1); #1;
    chk("R3 blocked no request", mem_req_valid, 0);
    idle();
    mem_retry = 1; mem_req_ready = 0; #1;
    chk_req("R5 resend refused", 1, 32'h0000_6000, rid);
    tick();
    chk("R5 still blocked", cache_blocked, 1);
    chk("R5 still waiting retry", st_of(1), 2);
    mem_retry = 1; #1;
    chk_req("R5 resend accepted", 1, 32'h0000_6000, rid);
    tick();
    chk("R5 block cleared", cache_blocked, 0);
    chk("R5 waiting response", st_of(1), 1);
    set_rsp(1, rid, mk_line(32'h66)); tick();
    chk("R5 fill after retry", st_of(1), 4);
  endtask

  task automatic t_owner_squash();
    int rid;
    rid = exp_rid;
    set_fetch(0, 32'h0000_9000, 1'b0); tick(); exp_rid++;
    chk("R4 blocked again", cache_blocked, 1);
    squash_valid = 1; squash_tid = 0; tick();
    chk("R9 squash state", st_of(0), 5);
    chk("R6 block kept", cache_blocked, 1);
    mem_retry = 1; #1;
    chk("R6 nothing resent", mem_req_valid, 0);
    tick();
    chk("R5 empty slot retry clears", cache_blocked, 0);
    set_rsp(0, rid, mk_line(32'h99)); #1;
    chk("R8 squashed id dropped", rsp_drop, 1);
    tick();
    chk("R8 squash state kept", st_of(0), 5);
    fill(0, 32'h0000_9000, mk_line(32'h9A));
  endtask

  task automatic t_same_cycle();
    int rid;
    rid = exp_rid;
    set_fetch(1, 32'h0000_A000, 1'b1); tick(); exp_rid++;
    set_rsp(1, rid, mk_line(32'hAA)); squash_valid = 1; squash_tid = 1; #1;
    chk("R9 response with squash dropped", rsp_drop, 1);
    tick();
    chk("R9 squash wins", st_of(1), 5);
    set_fetch(1, 32'h0000_A000, 1'b1); #1;
    chk("R9 line not written", fetch_hit, 0);
    chk_req("R9 fresh request", 1, 32'h0000_A000, exp_rid);
    tick(); exp_rid++;
    set_rsp(1, exp_rid - 1, mk_line(32'hAB)); tick();
    chk("R9 fresh fill", st_of(1), 4);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    stall_in = 2'b00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hit();
    t_stall_fill();
    t_stale();
    t_gate();
    t_refuse_retry();
    t_owner_squash();
    t_same_cycle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule